// File: doc/BRIEF.md
# Trigger Item Formation Unit

This unit evaluates one bunch crossing per clock. A vector of already-aligned trigger input bits is first widened by a lookup stage: a few multi-bit multiplicity fields at the bottom of the input vector are each turned into threshold condition bits through a programmable table. The combined condition vector is matched against a set of programmable trigger items. Each item has a care-mask and a required-value pattern, so any subset of conditions can be demanded at any polarity.

Every matching item passes through its own enable bit and its own prescaler. The survivors are ORed into a level-1 accept, which is then gated by three things. An external busy input throttles it. A simple dead-time holds off a programmable number of crossings after each accept. A token bucket refuses low-priority items while it is empty. Each accept carries an 8-bit trigger-type code. The unit also presents, for readout, the raw inputs, the item vector before masking and the item vector after mask and prescale.

The unit is set up through a write-only register port. Outputs are registered, so the results for a crossing appear one clock after its inputs are presented.

Top module: `trig_item_unit`

## Requirements
- R1: An item matches when, for every condition bit whose care bit is 1, the condition bit equals the item's value bit. Condition bits [N_IN-1:0] are `trig_in`. Bits N_IN + f*NCB + k are the lookup outputs for field f.
- R2: Lookup field f is `trig_in[f*FLD_W +: FLD_W]`. That field value selects table entry f*2^FLD_W + value, and the entry's NCB bits become the field's condition bits. The table resets to zero.
- R3: An item whose enable bit is 0 never contributes to the accept, the type or the after-prescale vector, whatever its match result.
- R4: With a prescale value P > 1, an enabled matching item survives on its P-th, 2P-th, ... match counted since reset or since the last write of its control word. A value of 0 or 1 passes every match. The counter advances on every enabled match, whether or not the accept is vetoed.
- R5: `l1a_o` is high in the clock after a crossing in which at least one surviving item is allowed and no veto applies.
- R6: A crossing presented with `busy_in` high produces no accept.
- R7: With dead-time D, the D crossings after an accepted crossing produce no accept.
- R8: Bucket size 0 disables the bucket. Writing size S fills it to S. Each accept takes one token when one is present. With period T > 0, one token is added every T crossings, up to S; T = 0 adds none. While the bucket is empty, low-priority items are not allowed, and high-priority items are unaffected.
- R9: `ttype_o` carries the code of the highest-numbered allowed surviving item. It is 0 when there is no accept.
- R10: With an accept, `rd_inputs_o`, `rd_raw_o` and `rd_final_o` give that crossing's `trig_in`, the match vector, and the post-mask-and-prescale vector (before vetoes). All three are zero without an accept.
- R11: Writes use `cfg_addr[11:8]` as region and `cfg_addr[7:0]` as index:
  - region 0: care word, index item*2 + word.
  - region 1: value word, same indexing.
  - region 2: item control, index = item. Bits [15:0] prescale, [16] enable, [17] high priority, [31:24] code.
  - region 3: lookup entry, data in bits [NCB-1:0].
  - region 4: index 0 dead-time, index 1 bucket size, index 2 refill period.
  After reset, every item is disabled and no accept occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | N_IN | Aligned trigger input bits for this crossing |
| busy_in | input | 1 | Throttle from downstream; blocks accepts |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4+IDX_W | Region (top 4 bits) and index |
| cfg_wdata | input | 32 | Configuration write data |
| l1a_o | output | 1 | Level-1 accept |
| ttype_o | output | 8 | Trigger-type code |
| rd_inputs_o | output | N_IN | Readout: input vector of the accepted crossing |
| rd_raw_o | output | N_ITEM | Readout: item matches before mask |
| rd_final_o | output | N_ITEM | Readout: items after mask and prescale |

## Verification
The hardest situation to reach is when the bucket and the prescalers interact. In that case a low-priority item keeps its prescale phase even though it is refused because the bucket is empty. Meanwhile a high-priority item in the same crossing still fires and drains no token, because the bucket is already at zero. To reach it, the stimulus sets a small bucket with a slow refill period, gives one low-priority and one high-priority item overlapping input bits, and feeds long runs in which both match. A behavioural model then tracks the counters, tokens and hold-off every clock.

// File: rtl/tiu_pkg.sv
package tiu_pkg;
  localparam int CFG_DW = 32;
  localparam int TT_W   = 8;
  localparam int PS_W   = 16;

  typedef enum logic [3:0] {
    RG_CARE = 4'd0,
    RG_VAL  = 4'd1,
    RG_CTRL = 4'd2,
    RG_LUT  = 4'd3,
    RG_GLB  = 4'd4
  } cfg_region_e;

  typedef struct packed {
    logic [TT_W-1:0] code;
    logic            hi;
    logic            en;
    logic [PS_W-1:0] ps;
  } item_ctrl_t;
endpackage

// File: rtl/tiu_cond_lut.sv
module tiu_cond_lut import tiu_pkg::*; #(
  parameter int N_IN  = 32,
  parameter int N_FLD = 4,
  parameter int FLD_W = 3,
  parameter int NCB   = 4,
  parameter int IDX_W = 8,
  localparam int ENT    = 1 << FLD_W,
  localparam int NLUT   = N_FLD * ENT,
  localparam int COND_W = N_IN + N_FLD * NCB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  cfg_region_e       cfg_region,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic [N_IN-1:0]   trig_in,
  output logic [COND_W-1:0] cond_o
);
  logic [NCB-1:0]       lut_q [NLUT];
  logic [N_FLD*NCB-1:0] thr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NLUT; k++) lut_q[k] <= '0;
    end else if (cfg_we && cfg_region == RG_LUT) begin
      for (int k = 0; k < NLUT; k++)
        if (cfg_idx == IDX_W'(k)) lut_q[k] <= cfg_wdata[NCB-1:0];
    end
  end

  always_comb begin
    thr = '0;
    for (int f = 0; f < N_FLD; f++)
      thr[f*NCB +: NCB] = lut_q[f*ENT + int'(trig_in[f*FLD_W +: FLD_W])];
  end

  assign cond_o = {thr, trig_in};
endmodule

// File: rtl/tiu_item.sv
module tiu_item import tiu_pkg::*; #(
  parameter int COND_W  = 48,
  parameter int IDX_W   = 8,
  parameter int ITEM_ID = 0,
  localparam int NWORD  = (COND_W + CFG_DW - 1) / CFG_DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  cfg_region_e       cfg_region,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic [COND_W-1:0] cond_i,
  output logic              raw_o,
  output logic              pass_o,
  output logic              hi_o,
  output logic [TT_W-1:0]   code_o
);
  logic [NWORD*CFG_DW-1:0] care_q, val_q;
  item_ctrl_t              ctrl_q;
  logic [PS_W-1:0]         cnt_q;
  logic                    masked, last_hit, ctrl_wr;

  function automatic logic f_match(input logic [COND_W-1:0] care,
                                   input logic [COND_W-1:0] val,
                                   input logic [COND_W-1:0] x);
    logic ok;
    ok = 1'b1;
    for (int b = 0; b < COND_W; b++)
      if (care[b] && (x[b] != val[b])) ok = 1'b0;
    return ok;
  endfunction

  assign ctrl_wr  = cfg_we && cfg_region == RG_CTRL && cfg_idx == IDX_W'(ITEM_ID);
  assign raw_o    = f_match(care_q[COND_W-1:0], val_q[COND_W-1:0], cond_i);
  assign masked   = raw_o && ctrl_q.en;
  assign last_hit = (ctrl_q.ps <= PS_W'(1)) || (cnt_q == ctrl_q.ps - PS_W'(1));
  assign pass_o   = masked && last_hit;
  assign hi_o     = ctrl_q.hi;
  assign code_o   = ctrl_q.code;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      care_q <= '0;
      val_q  <= '0;
    end else if (cfg_we) begin
      for (int w = 0; w < NWORD; w++) begin
        if (cfg_region == RG_CARE && cfg_idx == IDX_W'(ITEM_ID*NWORD + w))
          care_q[w*CFG_DW +: CFG_DW] <= cfg_wdata;
        if (cfg_region == RG_VAL && cfg_idx == IDX_W'(ITEM_ID*NWORD + w))
          val_q[w*CFG_DW +: CFG_DW] <= cfg_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q.ps   <= PS_W'(1);
      ctrl_q.en   <= 1'b0;
      ctrl_q.hi   <= 1'b0;
      ctrl_q.code <= '0;
      cnt_q       <= '0;
    end else if (ctrl_wr) begin
      ctrl_q.ps   <= cfg_wdata[PS_W-1:0];
      ctrl_q.en   <= cfg_wdata[16];
      ctrl_q.hi   <= cfg_wdata[17];
      ctrl_q.code <= cfg_wdata[31:24];
      cnt_q       <= '0;
    end else if (masked) begin
      cnt_q <= last_hit ? '0 : cnt_q + PS_W'(1);
    end
  end

  // Prescale phase stays strictly inside its window (R4)
  assert_prescale_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.ps > PS_W'(1)) |-> (cnt_q < ctrl_q.ps));
endmodule

// File: rtl/tiu_deadtime.sv
module tiu_deadtime import tiu_pkg::*; #(
  parameter int IDX_W = 8,
  parameter int CNT_W = 16,
  parameter int LVL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  cfg_region_e       cfg_region,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              busy_i,
  input  logic              cand_hi_i,
  input  logic              cand_lo_i,
  output logic              lo_ok_o,
  output logic              accept_o
);
  logic [CNT_W-1:0] dt_len_q, per_q, sdt_q, rcnt_q;
  logic [LVL_W-1:0] size_q, lvl_q, lvl_nx;
  logic             tick, glb_wr;

  assign glb_wr   = cfg_we && cfg_region == RG_GLB;
  assign lo_ok_o  = (size_q == '0) || (lvl_q != '0);
  assign accept_o = !busy_i && (sdt_q == '0) && (cand_hi_i || (cand_lo_i && lo_ok_o));
  assign tick     = (per_q != '0) && (rcnt_q == per_q - CNT_W'(1));

  always_comb begin
    lvl_nx = lvl_q;
    if (accept_o && lvl_nx != '0) lvl_nx = lvl_nx - LVL_W'(1);
    if (tick && lvl_nx < size_q)  lvl_nx = lvl_nx + LVL_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dt_len_q <= '0;
      size_q   <= '0;
      per_q    <= '0;
      sdt_q    <= '0;
      lvl_q    <= '0;
      rcnt_q   <= '0;
    end else begin
      if (accept_o)            sdt_q <= dt_len_q;
      else if (sdt_q != '0)    sdt_q <= sdt_q - CNT_W'(1);

      if (glb_wr && cfg_idx == IDX_W'(2)) begin
        per_q  <= cfg_wdata[CNT_W-1:0];
        rcnt_q <= '0;
      end else begin
        rcnt_q <= (tick || per_q == '0) ? '0 : rcnt_q + CNT_W'(1);
      end

      if (glb_wr && cfg_idx == IDX_W'(1)) begin
        size_q <= cfg_wdata[LVL_W-1:0];
        lvl_q  <= cfg_wdata[LVL_W-1:0];
      end else begin
        lvl_q  <= lvl_nx;
      end

      if (glb_wr && cfg_idx == IDX_W'(0)) dt_len_q <= cfg_wdata[CNT_W-1:0];
    end
  end

  // Token count never exceeds configured bucket size (R8)
  assert_bucket_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= size_q);
  // An accept with non-zero hold-off is followed by a quiet crossing (R7)
  assert_holdoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && dt_len_q != '0 && !glb_wr) |=> !accept_o);
  // Empty bucket admits no accept unless a high-priority item is present (R8)
  assert_lo_veto_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && !lo_ok_o) |-> cand_hi_i);
endmodule

// File: rtl/trig_item_unit.sv
module trig_item_unit import tiu_pkg::*; #(
  parameter int N_IN   = 32,
  parameter int N_ITEM = 16,
  parameter int N_FLD  = 4,
  parameter int FLD_W  = 3,
  parameter int NCB    = 4,
  parameter int IDX_W  = 8,
  parameter int CNT_W  = 16,
  parameter int LVL_W  = 8,
  localparam int AW     = 4 + IDX_W,
  localparam int COND_W = N_IN + N_FLD * NCB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   trig_in,
  input  logic              busy_in,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic              l1a_o,
  output logic [TT_W-1:0]   ttype_o,
  output logic [N_IN-1:0]   rd_inputs_o,
  output logic [N_ITEM-1:0] rd_raw_o,
  output logic [N_ITEM-1:0] rd_final_o
);
  cfg_region_e            cfg_region;
  logic [IDX_W-1:0]       cfg_idx;
  logic [COND_W-1:0]      cond;
  logic [N_ITEM-1:0]      raw_vec, pass_vec, hi_vec, allow_vec;
  logic [N_ITEM*TT_W-1:0] code_flat;
  logic                   lo_ok, accept, cand_hi, cand_lo;
  logic [TT_W-1:0]        code_sel;

  function automatic logic [TT_W-1:0] f_top_code(input logic [N_ITEM-1:0] set,
                                                 input logic [N_ITEM*TT_W-1:0] codes);
    logic [TT_W-1:0] r;
    r = '0;
    for (int i = 0; i < N_ITEM; i++)
      if (set[i]) r = codes[i*TT_W +: TT_W];
    return r;
  endfunction

  assign cfg_region = cfg_region_e'(cfg_addr[AW-1 -: 4]);
  assign cfg_idx    = cfg_addr[IDX_W-1:0];

  tiu_cond_lut #(.N_IN(N_IN), .N_FLD(N_FLD), .FLD_W(FLD_W), .NCB(NCB), .IDX_W(IDX_W)) u_lut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_region(cfg_region),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .trig_in(trig_in), .cond_o(cond));

  for (genvar i = 0; i < N_ITEM; i++) begin : g_item
    tiu_item #(.COND_W(COND_W), .IDX_W(IDX_W), .ITEM_ID(i)) u_item (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_region(cfg_region),
      .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cond_i(cond),
      .raw_o(raw_vec[i]), .pass_o(pass_vec[i]), .hi_o(hi_vec[i]),
      .code_o(code_flat[i*TT_W +: TT_W]));
  end

  assign cand_hi   = |(pass_vec & hi_vec);
  assign cand_lo   = |(pass_vec & ~hi_vec);
  assign allow_vec = pass_vec & (hi_vec | {N_ITEM{lo_ok}});
  assign code_sel  = f_top_code(allow_vec, code_flat);

  tiu_deadtime #(.IDX_W(IDX_W), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_dead (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_region(cfg_region),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .busy_i(busy_in),
    .cand_hi_i(cand_hi), .cand_lo_i(cand_lo), .lo_ok_o(lo_ok), .accept_o(accept));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l1a_o       <= 1'b0;
      ttype_o     <= '0;
      rd_inputs_o <= '0;
      rd_raw_o    <= '0;
      rd_final_o  <= '0;
    end else begin
      l1a_o       <= accept;
      ttype_o     <= accept ? code_sel : '0;
      rd_inputs_o <= accept ? trig_in  : '0;
      rd_raw_o    <= accept ? raw_vec  : '0;
      rd_final_o  <= accept ? pass_vec : '0;
    end
  end

  // Every accept is backed by at least one surviving item (R5)
  assert_accept_has_item_R5: assert property (@(posedge clk) disable iff (!rst_n)
    l1a_o |-> (rd_final_o != '0));
  // A busy crossing yields no accept in the next clock (R6)
  assert_busy_throttle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_in |=> !l1a_o);
  // Surviving items are a subset of matching items (R3)
  assert_final_in_raw_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_final_o & ~rd_raw_o) == '0);
endmodule

// File: tb/tb_trig_item_unit.sv
module tb_trig_item_unit;
  localparam int TCK = 10;
  localparam int NI = 32, NT = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NI-1:0] trig_in = '0;
  logic          busy_in = 1'b0;
  logic          cfg_we = 1'b0;
  logic [11:0]   cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          l1a_o;
  logic [7:0]    ttype_o;
  logic [NI-1:0] rd_inputs_o;
  logic [NT-1:0] rd_raw_o, rd_final_o;

  trig_item_unit dut (.clk(clk), .rst_n(rst_n), .trig_in(trig_in), .busy_in(busy_in),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .l1a_o(l1a_o),
    .ttype_o(ttype_o), .rd_inputs_o(rd_inputs_o), .rd_raw_o(rd_raw_o), .rd_final_o(rd_final_o));

  always #(TCK/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  string tag = "R11";

  // behavioural reference state
  logic [63:0] m_care [NT];
  logic [63:0] m_val  [NT];
  int m_ps [NT], m_cnt [NT], m_code [NT];
  bit m_en [NT], m_hi [NT];
  int m_lut [32];
  int m_dt, m_size, m_per, m_sdt, m_lvl, m_rcnt;
  logic          e_l1a;
  logic [7:0]    e_tt;
  logic [NI-1:0] e_in;
  logic [NT-1:0] e_raw, e_fin;

  function automatic void model_reset();
    for (int i = 0; i < NT; i++) begin
      m_care[i] = '0; m_val[i] = '0; m_ps[i] = 1; m_cnt[i] = 0;
      m_code[i] = 0; m_en[i] = 0; m_hi[i] = 0;
    end
    for (int k = 0; k < 32; k++) m_lut[k] = 0;
    m_dt = 0; m_size = 0; m_per = 0; m_sdt = 0; m_lvl = 0; m_rcnt = 0;
    e_l1a = 0; e_tt = 0; e_in = 0; e_raw = 0; e_fin = 0;
  endfunction

  function automatic void model_step();
    logic [47:0] cond;
    logic [NT-1:0] raw, fin;
    bit ok, acc, tick, any_allowed;
    int tt, rg, ix;
    cond[31:0] = trig_in;
    for (int f = 0; f < 4; f++) cond[32+f*4 +: 4] = 4'(m_lut[f*8 + int'(trig_in[f*3 +: 3])]);
    raw = '0; fin = '0; any_allowed = 0; tt = 0;
    for (int i = 0; i < NT; i++) begin
      ok = 1;
      for (int b = 0; b < 48; b++) if (m_care[i][b] && cond[b] !== m_val[i][b]) ok = 0;
      raw[i] = ok;
      if (ok && m_en[i]) begin
        if (m_ps[i] <= 1) fin[i] = 1;
        else begin
          m_cnt[i]++;
          if (m_cnt[i] == m_ps[i]) begin fin[i] = 1; m_cnt[i] = 0; end
        end
      end
    end
    for (int i = 0; i < NT; i++)
      if (fin[i] && (m_hi[i] || m_size == 0 || m_lvl > 0)) begin
        any_allowed = 1; tt = m_code[i];
      end
    acc = !busy_in && m_sdt == 0 && any_allowed;
    e_l1a = acc; e_tt = acc ? 8'(tt) : 8'h0;
    e_in = acc ? trig_in : '0; e_raw = acc ? raw : '0; e_fin = acc ? fin : '0;
    if (acc) m_sdt = m_dt; else if (m_sdt > 0) m_sdt--;
    if (acc && m_lvl > 0) m_lvl--;
    tick = m_per != 0 && m_rcnt == m_per - 1;
    if (tick && m_lvl < m_size) m_lvl++;
    m_rcnt = (tick || m_per == 0) ? 0 : m_rcnt + 1;
    if (cfg_we) begin
      rg = int'(cfg_addr[11:8]); ix = int'(cfg_addr[7:0]);
      if (rg == 0 && ix < 2*NT) m_care[ix/2][(ix%2)*32 +: 32] = cfg_wdata;
      if (rg == 1 && ix < 2*NT) m_val[ix/2][(ix%2)*32 +: 32] = cfg_wdata;
      if (rg == 2 && ix < NT) begin
        m_ps[ix] = int'(cfg_wdata[15:0]); m_en[ix] = cfg_wdata[16];
        m_hi[ix] = cfg_wdata[17]; m_code[ix] = int'(cfg_wdata[31:24]); m_cnt[ix] = 0;
      end
      if (rg == 3 && ix < 32) m_lut[ix] = int'(cfg_wdata[3:0]);
      if (rg == 4 && ix == 0) m_dt = int'(cfg_wdata[15:0]);
      if (rg == 4 && ix == 1) begin m_size = int'(cfg_wdata[7:0]); m_lvl = m_size; end
      if (rg == 4 && ix == 2) begin m_per = int'(cfg_wdata[15:0]); m_rcnt = 0; end
    end
  endfunction

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // model one crossing with the inputs currently driven, then compare after the edge
  task automatic step();
    if (!rst_n) model_reset(); else model_step();
    @(negedge clk);
    chk("l1a (R5)", 64'(l1a_o), 64'(e_l1a));
    chk("ttype (R9)", 64'(ttype_o), 64'(e_tt));
    chk("rd_inputs (R10)", 64'(rd_inputs_o), 64'(e_in));
    chk("rd_raw (R1)", 64'(rd_raw_o), 64'(e_raw));
    chk("rd_final (R4)", 64'(rd_final_o), 64'(e_fin));
  endtask

  task automatic wr(input int rg, input int ix, input logic [31:0] d);
    cfg_we = 1; cfg_addr = {4'(rg), 8'(ix)}; cfg_wdata = d;
    step();
    cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
  endtask

  function automatic logic [31:0] ctl(input int ps, input bit en, input bit hi, input int code);
    return {8'(code), 6'd0, hi, en, 16'(ps)};
  endfunction

  task automatic run(input int n, input int busy_pct, input logic [31:0] force_mask);
    for (int c = 0; c < n; c++) begin
      trig_in = $urandom() | ($urandom_range(0, 1) ? force_mask : 32'h0);
      busy_in = ($urandom_range(0, 99) < busy_pct);
      step();
    end
    trig_in = '0; busy_in = 0;
  endtask

  initial begin
    #(TCK * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    tag = "R11";
    trig_in = 32'hFFFF_FFFF;
    for (int c = 0; c < 3; c++) step();           // reset state
    rst_n = 1;
    run(30, 0, 32'h0);                            // R11: nothing enabled, no accept

    tag = "R1";                                   // item0: bit5=1, bit9=0
    wr(0, 0, 32'h0000_0220); wr(1, 0, 32'h0000_0020); wr(2, 0, ctl(1, 1, 1, 8'h11));
    trig_in = 32'h0000_0020; step();
    trig_in = 32'h0000_0220; step();
    trig_in = 32'h0000_0000; step();
    run(60, 0, 32'h0);

    tag = "R2";                                   // field1 values 3..7 -> cond bit 38
    for (int e = 3; e < 8; e++) wr(3, 8 + e, 32'h4);
    wr(0, 3, 32'h40); wr(1, 3, 32'h40); wr(2, 1, ctl(1, 1, 1, 8'h22));
    for (int v = 0; v < 8; v++) begin trig_in = 32'(v) << 3; step(); end
    run(60, 0, 32'h0);

    tag = "R3";
    wr(2, 0, ctl(1, 0, 1, 8'h11));
    run(60, 0, 32'h0);
    wr(2, 0, ctl(1, 1, 1, 8'h11));

    tag = "R4";                                   // item2: bit20, prescale 3
    wr(2, 1, ctl(1, 0, 1, 8'h22)); wr(2, 0, ctl(1, 0, 1, 8'h11));
    wr(0, 4, 32'h0010_0000); wr(1, 4, 32'h0010_0000); wr(2, 2, ctl(3, 1, 1, 8'h33));
    for (int c = 0; c < 10; c++) begin trig_in = 32'h0010_0000; step(); end
    run(60, 0, 32'h0010_0000);

    tag = "R5";
    wr(2, 0, ctl(1, 1, 1, 8'h11)); wr(2, 1, ctl(1, 1, 1, 8'h22));
    run(80, 0, 32'h0);

    tag = "R6";
    run(100, 40, 32'h0);

    tag = "R7";
    wr(4, 0, 32'd2);
    run(100, 0, 32'h0000_0020);
    wr(4, 0, 32'd0);

    tag = "R8";                                   // item3 low bit21, item4 high bit22
    wr(2, 0, ctl(1, 0, 1, 8'h11)); wr(2, 1, ctl(1, 0, 1, 8'h22)); wr(2, 2, ctl(3, 0, 1, 8'h33));
    wr(0, 6, 32'h0020_0000); wr(1, 6, 32'h0020_0000); wr(2, 3, ctl(2, 1, 0, 8'h44));
    wr(0, 8, 32'h0040_0000); wr(1, 8, 32'h0040_0000); wr(2, 4, ctl(1, 1, 1, 8'h55));
    wr(4, 1, 32'd2); wr(4, 2, 32'd5);
    for (int c = 0; c < 20; c++) begin trig_in = 32'h0020_0000; step(); end
    for (int c = 0; c < 20; c++) begin trig_in = 32'h0060_0000; step(); end
    run(200, 10, 32'h0060_0000);
    wr(4, 2, 32'd0);
    run(60, 0, 32'h0060_0000);

    tag = "R9";                                   // many items with distinct codes
    for (int i = 5; i < NT; i++) begin
      wr(0, 2*i, 32'(1) << (i + 8)); wr(1, 2*i, 32'(1) << (i + 8));
      wr(2, i, ctl(i % 3, 1, i % 2, 16 * i + 3));
    end
    wr(2, 0, ctl(1, 1, 1, 8'h11)); wr(2, 1, ctl(2, 1, 0, 8'h22));
    wr(4, 1, 32'd3); wr(4, 2, 32'd7);
    run(300, 0, 32'h0);

    tag = "R10";
    wr(4, 0, 32'd1);
    run(1500, 15, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule